// File: doc/BRIEF.md
# Conversion Result FIFO with Fill Status

This block sits between the end of an analog-to-digital conversion pipeline and the output register of the converter. Each result word is 18 bits wide: 16 data bits, a copy of the most significant bit and an overflow flag. The block stores up to 16 of these words. A single mode input chooses between two paths. In pass-through mode each new result goes directly to the output. In queued mode every completed conversion is stored, and a read line steps the output through the stored words from oldest to newest.

A write strobe marks each completed conversion. It is a one-cycle pulse made from the end-of-conversion falling edge. In queued mode the first word written into an empty queue appears on the output at once, with no read needed. Each rising edge of the read line then brings the next word forward. Results that arrive while the queue is full are dropped. A two-bit status code reports the fill level, and it includes a half-full threshold. The queue is cleared when the mode input and the read line are both held low.

Top module: `conv_result_fifo`

## Requirements
- R1: While rst_ni is low, and after it is released, stat_o is 2'b01 (empty) and head_o is zero.
- R2: When fifo_mode_i is 0, head_o shows the word taken with the last wr_stb_i, one cycle after the strobe. Read edges and strobes change neither the queue contents nor stat_o, unless the clear condition of R9 is met.
- R3: When fifo_mode_i is 1, every wr_stb_i is stored whatever level rd_line_i has.
- R4: A word written into an empty queue appears on head_o in the cycle after its strobe, with no read edge.
- R5: In queued mode, a sampled rising edge of rd_line_i replaces head_o with the next older stored word, one cycle after the edge.
- R6: A write while 16 words are held is dropped. stat_o stays 2'b11, and the dropped word never reaches head_o.
- R7: A rising read edge while the queue is empty leaves head_o and stat_o (2'b01) unchanged.
- R8: The stat_o code is {upper, lower}: 2'b01 for 0 words, 2'b00 for 1 to 7 words, 2'b10 for 8 to 15 words, and 2'b11 for 16 words.
- R9: A clock edge with fifo_mode_i=0 and rd_line_i=0 empties the queue, and stat_o reads 2'b01 after it.
- R10: When a rising read edge has brought forward the last stored word, stat_o shows 2'b00. It changes to 2'b01 only at the next falling edge of rd_line_i, and head_o keeps that last word.
- R11: A write and a read advance in the same cycle leave the number of held words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | 1 selects queued mode, 0 selects pass-through |
| rd_line_i | input | 1 | Read line; each rising edge advances the output |
| wr_stb_i | input | 1 | One-cycle strobe for a completed conversion |
| wr_data_i | input | 18 | Result word: [17] overflow, [16] MSB copy, [15:0] data |
| head_o | output | 18 | Oldest held word, or the pass-through word |
| stat_o | output | 2 | Fill level code, as defined in R8 |

## Verification
The bench uses the default parameters: 16-bit data, which gives 18-bit words, and a depth of 16. With these values the half-full threshold of 8 and the full level of 16 are both reached within a few dozen cycles. The bench fills the queue to full, drives one extra write to check that it is dropped, and then reads the queue back to empty one edge at a time. Along the way it watches stat_o move through every code. A short vector table covers the pass-through behaviour, the fall-through of the first word, and a read and write landing in the same cycle. Directed steps then check the delayed empty status and the clear through mode and read levels.

// File: rtl/cr_fifo_pkg.sv
package cr_fifo_pkg;
  typedef enum logic [1:0] {
    FILL_LOW   = 2'b00,
    FILL_EMPTY = 2'b01,
    FILL_HALF  = 2'b10,
    FILL_FULL  = 2'b11
  } fill_code_e;
endpackage

// File: rtl/cr_edge_det.sv
module cr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  // idle level of the read line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/cr_fifo_ctl.sv
module cr_fifo_ctl
  import cr_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int HALF  = DEPTH / 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       mode_i,
  input  logic       wr_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       wr_ok_o,
  output logic       pop_o,
  output logic       load_wr_o,
  output logic       load_mem_o,
  output fill_code_e stat_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q;
  logic             cnt_zero, cnt_one, cnt_many, adv, fin;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_one  = (cnt_q == CNT_W'(1));
  assign cnt_many = (cnt_q >= CNT_W'(2));

  assign wr_ok_o = mode_i & wr_i & (cnt_q != CNT_W'(DEPTH));
  // step to next word; with one word held only a same-cycle write gives a next word
  assign adv     = mode_i & rise_i & (cnt_many | (cnt_one & wr_ok_o));
  // last word retired on the falling read edge
  assign fin     = mode_i & fall_i & pend_q;
  assign pop_o   = adv | fin;

  assign load_wr_o  = wr_ok_o & (cnt_zero | fin | (adv & cnt_one));
  assign load_mem_o = adv & cnt_many;

  assign cnt_d = cnt_q + CNT_W'(wr_ok_o) - CNT_W'(pop_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (mode_i && rise_i && !cnt_zero && cnt_d == CNT_W'(1)) pend_q <= 1'b1;
      else if (fin || wr_ok_o)                                 pend_q <= 1'b0;
    end
  end

  always_comb begin
    if (cnt_zero)                       stat_o = FILL_EMPTY;
    else if (cnt_q >= CNT_W'(DEPTH))    stat_o = FILL_FULL;
    else if (cnt_q >= CNT_W'(HALF))     stat_o = FILL_HALF;
    else                                stat_o = FILL_LOW;
  end
endmodule

// File: rtl/cr_fifo_store.sv
module cr_fifo_store #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic              pop_i,
  input  logic              load_wr_i,
  input  logic              load_mem_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] head_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [IDX_W-1:0]  nxt_idx;
  logic [WORD_W-1:0] head_q;

  assign nxt_idx = rd_ptr_q[IDX_W-1:0] + IDX_W'(1);

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q[IDX_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_i)  wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (pop_i) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
    end
  end

  // head survives a clear: last word stays on the output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         head_q <= '0;
    else if (clr_i)      head_q <= head_q;
    else if (load_wr_i)  head_q <= wr_data_i;
    else if (load_mem_i) head_q <= mem_q[nxt_idx];
  end

  assign head_o = head_q;
endmodule

// File: rtl/conv_result_fifo.sv
module conv_result_fifo
  import cr_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int WORD_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_mode_i,
  input  logic              rd_line_i,
  input  logic              wr_stb_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] head_o,
  output logic [1:0]        stat_o
);
  logic              rise, fall, clr;
  logic              wr_ok, pop, load_wr, load_mem;
  logic [WORD_W-1:0] fifo_head, dir_q;
  fill_code_e        fill;

  assign clr = ~fifo_mode_i & ~rd_line_i;

  cr_edge_det u_rd_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (rd_line_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  cr_fifo_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .mode_i     (fifo_mode_i),
    .wr_i       (wr_stb_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .wr_ok_o    (wr_ok),
    .pop_o      (pop),
    .load_wr_o  (load_wr),
    .load_mem_o (load_mem),
    .stat_o     (fill)
  );

  cr_fifo_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .wr_i       (wr_ok),
    .pop_i      (pop),
    .load_wr_i  (load_wr),
    .load_mem_i (load_mem),
    .wr_data_i  (wr_data_i),
    .head_o     (fifo_head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      dir_q <= '0;
    else if (!fifo_mode_i && wr_stb_i) dir_q <= wr_data_i;
  end

  assign head_o = fifo_mode_i ? fifo_head : dir_q;
  assign stat_o = fill;
endmodule

// File: rtl/conv_result_fifo_chk.sv
module conv_result_fifo_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_mode_i,
  input logic              rd_line_i,
  input logic              wr_stb_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic [WORD_W-1:0] head_o,
  input logic [1:0]        stat_o
);
  logic rd_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_prev_q <= 1'b1;
    else         rd_prev_q <= rd_line_i;
  end

  p_direct_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_mode_i && wr_stb_i) ##1 !fifo_mode_i |-> head_o == $past(wr_data_i));

  p_direct_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_mode_i && rd_line_i) |=> $stable(stat_o));

  p_fall_through_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode_i && stat_o == 2'b01 && wr_stb_i) ##1 fifo_mode_i |-> head_o == $past(wr_data_i));

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode_i && stat_o == 2'b11 && wr_stb_i && !(rd_line_i && !rd_prev_q)) |=> stat_o == 2'b11);

  p_empty_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode_i && stat_o == 2'b01 && !wr_stb_i) |=> stat_o == 2'b01);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_mode_i && !rd_line_i) |=> stat_o == 2'b01);
endmodule

bind conv_result_fifo conv_result_fifo_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_mode_i (fifo_mode_i),
  .rd_line_i   (rd_line_i),
  .wr_stb_i    (wr_stb_i),
  .wr_data_i   (wr_data_i),
  .head_o      (head_o),
  .stat_o      (stat_o)
);

// File: tb/conv_result_fifo_tb.sv
module conv_result_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 18;

  typedef struct packed {
    logic         mode;
    logic         rd;
    logic         wr;
    logic [W-1:0] data;
    logic [W-1:0] head;
    logic [1:0]   stat;
    logic [7:0]   req;
  } vec_t;

  // one entry per cycle; outputs checked at the end of that cycle
  localparam vec_t VECS [16] = '{
    '{1'b0, 1'b1, 1'b1, 18'h0AAAA, 18'h0AAAA, 2'b01, 8'd2},  // R2 pass-through load
    '{1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h0AAAA, 2'b01, 8'd2},  // R2 no strobe, no change
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h00000, 2'b01, 8'd8},  // R8 empty code
    '{1'b1, 1'b1, 1'b1, 18'h00011, 18'h00011, 2'b00, 8'd4},  // R4 fall-through
    '{1'b1, 1'b0, 1'b1, 18'h00022, 18'h00011, 2'b00, 8'd3},  // R3 write with read low
    '{1'b1, 1'b0, 1'b0, 18'h00000, 18'h00011, 2'b00, 8'd3},  // R3
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h00022, 2'b00, 8'd5},  // R5 rising edge advances
    '{1'b1, 1'b1, 1'b1, 18'h00033, 18'h00022, 2'b00, 8'd5},  // R5 level high, no advance
    '{1'b1, 1'b0, 1'b0, 18'h00000, 18'h00022, 2'b00, 8'd5},  // R5
    '{1'b1, 1'b1, 1'b1, 18'h00044, 18'h00033, 2'b00, 8'd11}, // R11 read+write together
    '{1'b1, 1'b0, 1'b0, 18'h00000, 18'h00033, 2'b00, 8'd11}, // R11
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h00044, 2'b00, 8'd11}, // R11 two held, last word now
    '{1'b1, 1'b0, 1'b0, 18'h00000, 18'h00044, 2'b01, 8'd10}, // R10 empty on falling edge
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h00044, 2'b01, 8'd7},  // R7 read when empty
    '{1'b1, 1'b0, 1'b0, 18'h00000, 18'h00044, 2'b01, 8'd7},  // R7
    '{1'b0, 1'b1, 1'b0, 18'h00000, 18'h0AAAA, 2'b01, 8'd2}   // R2 pass-through word kept
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         fifo_mode_i = 1'b0;
  logic         rd_line_i = 1'b1;
  logic         wr_stb_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] head_o;
  logic [1:0]   stat_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  conv_result_fifo u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_mode_i (fifo_mode_i),
    .rd_line_i   (rd_line_i),
    .wr_stb_i    (wr_stb_i),
    .wr_data_i   (wr_data_i),
    .head_o      (head_o),
    .stat_o      (stat_o)
  );

  task automatic step(input logic m, input logic r, input logic w, input logic [W-1:0] d);
    fifo_mode_i = m;
    rd_line_i   = r;
    wr_stb_i    = w;
    wr_data_i   = d;
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] eh, input logic [1:0] es);
    checks++;
    if (head_o !== eh || stat_o !== es) begin
      errors++;
      $display("FAIL %s: head=%h stat=%b expected head=%h stat=%b", tag, head_o, stat_o, eh, es);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", '0, 2'b01);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", '0, 2'b01);

    foreach (VECS[i]) begin
      step(VECS[i].mode, VECS[i].rd, VECS[i].wr, VECS[i].data);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].head, VECS[i].stat);
    end

    // R8 / R6: fill to full, expecting every level code on the way
    step(1'b1, 1'b1, 1'b0, '0);
    for (int k = 0; k < 16; k++) begin
      step(1'b1, 1'b1, 1'b1, 18'h00100 + W'(k));
      if (k == 6)  chk("R8 seven words", 18'h00100, 2'b00);
      if (k == 7)  chk("R8 eight words", 18'h00100, 2'b10);
      if (k == 14) chk("R8 fifteen words", 18'h00100, 2'b10);
      if (k == 15) chk("R8 sixteen words", 18'h00100, 2'b11);
    end
    step(1'b1, 1'b1, 1'b1, 18'h3FFFF);
    chk("R6 write to full dropped", 18'h00100, 2'b11);
    step(1'b1, 1'b0, 1'b0, '0);

    // R5 / R6: fifteen rising edges walk words 2 to 16
    for (int k = 1; k <= 15; k++) begin
      step(1'b1, 1'b1, 1'b0, '0);
      if (k == 1)       chk("R5 first advance", 18'h00101, 2'b10);
      else if (k == 8)  chk("R8 eight left", 18'h00108, 2'b10);
      else if (k == 9)  chk("R8 seven left", 18'h00109, 2'b00);
      else if (k == 15) chk("R10 last word shown, not yet empty", 18'h0010F, 2'b00);
      step(1'b1, 1'b0, 1'b0, '0);
      if (k < 15 && head_o !== 18'h00100 + W'(k)) chk("R6 read order", 18'h00100 + W'(k), stat_o);
    end
    chk("R10 empty after falling edge", 18'h0010F, 2'b01);
    step(1'b1, 1'b1, 1'b0, '0);
    chk("R7 read on empty keeps last word", 18'h0010F, 2'b01);

    // R9: clear through mode and read levels
    step(1'b1, 1'b1, 1'b1, 18'h00201);
    step(1'b1, 1'b1, 1'b1, 18'h00202);
    step(1'b1, 1'b1, 1'b1, 18'h00203);
    chk("R9 three words held", 18'h00201, 2'b00);
    step(1'b0, 1'b1, 1'b0, '0);
    chk("R2 pass-through keeps queue", 18'h0AAAA, 2'b00);
    step(1'b0, 1'b0, 1'b0, '0);
    chk("R9 clear gives empty", 18'h0AAAA, 2'b01);
    step(1'b1, 1'b1, 1'b0, '0);
    chk("R9 empty in queued mode", 18'h00201, 2'b01);
    step(1'b1, 1'b1, 1'b1, 18'h00300);
    chk("R9 next write falls through", 18'h00300, 2'b00);

    finish_run();
  end
endmodule